// File: doc/BRIEF.md
# Parallel Switch Layer Selector

This block serves one input port of a switch made of several slower switch layers working side by side. In each slot it takes at most one cell. The cell carries a tag that gives the slot in which it would leave an ideal first-come-first-served output-queued switch. The block assigns the cell to exactly one layer. That layer must meet two conditions: the input port's link to it is free in the current slot, and the cell's destination output can read from it at the tagged departure slot.

The output side supplies its availability for the departure slot as a per-layer bitmap that arrives with the cell. The block tracks its own link availability. Whenever a cell goes out on a layer, that layer's link stays occupied for ceil(layers / speedup) slots. When more than one layer qualifies, the lowest-numbered one wins. If no layer qualifies, the cell is discarded and an error strobe fires. With a speedup above two and a departure bitmap that holds enough layers, this case cannot arise.

Top module: `layer_select_demux`

## Requirements
- R1: While reset is held, and on the first clock edge that samples reset, `cell_ready`, `grant_valid` and `no_layer_err` are 0 and every layer link is free. From the first edge that samples reset deasserted, `cell_ready` is 1 and stays 1 in every later slot.
- R2: A cell accepted at a clock edge (`cell_valid` and `cell_ready` both 1) is reported after that same edge. When the candidate set (free links AND `depart_avail`) is not empty, `grant_valid` is 1 for one slot, and `grant_depart` and `grant_data` carry the cell's tag and payload.
- R3: The layer in `grant_layer` is the lowest index in the candidate set. Bit i of `depart_avail` stands for layer i.
- R4: A granted layer is excluded for the next BUSY-1 accepting slots and can be chosen again in the BUSY-th slot after its grant, where BUSY = ceil(NUM_LAYERS / SPEEDUP), which is 4 with the defaults.
- R5: A grant occupies only the link of the chosen layer. The occupancy of every other layer is unchanged.
- R6: When a cell is accepted and the candidate set is empty, `no_layer_err` is 1 for one slot, `grant_valid` stays 0, the cell is discarded, and no link is occupied.
- R7: In a slot without an accepted cell, `grant_valid` and `no_layer_err` are 0 after the next edge. The occupancy counts keep running down as usual.
- R8: `grant_valid` and `no_layer_err` are never 1 in the same slot.
- R9: With one cell per slot, if every departure bitmap holds at least BUSY layers, `no_layer_err` never fires. This holds because at most BUSY-1 links can be occupied at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_valid | input | 1 | A cell is offered in this slot |
| cell_ready | output | 1 | Block accepts a cell in this slot |
| cell_depart | input | TAG_W | Departure slot tag of the offered cell |
| cell_data | input | CELL_W | Payload of the offered cell |
| depart_avail | input | NUM_LAYERS | Layers the destination can read at the departure slot |
| grant_valid | output | 1 | A layer was chosen for the last accepted cell |
| grant_layer | output | IDX_W | Index of the chosen layer |
| grant_depart | output | TAG_W | Departure tag of the granted cell |
| grant_data | output | CELL_W | Payload of the granted cell |
| no_layer_err | output | 1 | Last accepted cell found no common layer and was dropped |

## Verification
The bench uses the default ten layers and a speedup of three. This gives an occupancy window of four slots, so back-to-back cells walk through layers 0 to 3 and come back to layer 0 in the fifth slot. Because the window is short, directed tests can reach the wrap-around, the exclusion of a busy layer, and a forced empty candidate set in only a few slots. A long stream of cells then uses departure bitmaps that each hold at least four layers. It confirms against a bench-side occupancy model that the error strobe never fires and that every choice is the lowest common layer.

// File: rtl/layer_select_pkg.sv
// Package: shared helpers for the layer selector.
// Holds the arithmetic used to size the occupancy window and counters.
package layer_select_pkg;

    // Integer ceiling division, used for the link occupancy window.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Result of an empty/non-empty candidate search.
    typedef enum logic [1:0] {
        PICK_IDLE = 2'd0,
        PICK_HIT  = 2'd1,
        PICK_MISS = 2'd2
    } pick_outcome_e;

endpackage

// File: rtl/layer_link_tracker.sv
// Module: layer_link_tracker
// Keeps one down-counter per layer for the input port's link to that layer.
// A claim loads BUSY_SLOTS-1 into the claimed layer's counter; every other
// non-zero counter decrements once per slot. A link is free when its counter
// is zero. Assumes at most one claim per slot.
module layer_link_tracker #(
    parameter int NUM_LAYERS = 10,
    parameter int BUSY_SLOTS = 4,
    parameter int IDX_W      = 4,
    parameter int CNT_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  claim_en,
    input  logic [IDX_W-1:0]      claim_idx,
    output logic [NUM_LAYERS-1:0] link_free
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_SLOTS - 1);

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_link
        logic [CNT_W-1:0] busy_cnt;
        logic             hit;

        // Decode whether this layer is the one claimed in this slot.
        assign hit = claim_en && (claim_idx == IDX_W'(g));

        // Load on claim, otherwise count down towards free.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_cnt <= '0;
            end else if (hit) begin
                busy_cnt <= RELOAD;
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - CNT_W'(1);
            end
        end

        // Expose link availability for this layer.
        assign link_free[g] = (busy_cnt == '0);
    end

endmodule

// File: rtl/layer_lowest_pick.sv
// Module: layer_lowest_pick
// Combinational fixed-priority pick: returns the lowest set bit of the request
// vector as an index, plus a flag telling whether any bit was set.
// Assumes NUM_LAYERS fits in IDX_W bits.
module layer_lowest_pick #(
    parameter int NUM_LAYERS = 10,
    parameter int IDX_W      = 4
) (
    input  logic [NUM_LAYERS-1:0] req,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);

    logic [NUM_LAYERS:0]   seen;
    logic [NUM_LAYERS-1:0] onehot;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_chain
        // A bit wins only if no lower bit was already requesting.
        assign onehot[g]  = req[g] & ~seen[g];
        assign seen[g+1]  = seen[g] | req[g];
    end

    // Any request present.
    assign found = seen[NUM_LAYERS];

    // Encode the one-hot winner into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (onehot[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/layer_select_demux.sv
// Module: layer_select_demux
// Assigns each arriving cell to one switch layer whose input link is free now
// and which the destination output can read at the cell's departure slot.
// Outputs are registered one slot after acceptance. Assumes the departure
// bitmap is valid together with cell_valid; the block never back-pressures
// after reset.
module layer_select_demux
    import layer_select_pkg::*;
#(
    parameter int NUM_LAYERS = 10,
    parameter int SPEEDUP    = 3,
    parameter int TAG_W      = 16,
    parameter int CELL_W     = 32,
    localparam int IDX_W      = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1,
    localparam int BUSY_SLOTS = ceil_div(NUM_LAYERS, SPEEDUP),
    localparam int CNT_W      = $clog2(BUSY_SLOTS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cell_valid,
    output logic                  cell_ready,
    input  logic [TAG_W-1:0]      cell_depart,
    input  logic [CELL_W-1:0]     cell_data,
    input  logic [NUM_LAYERS-1:0] depart_avail,
    output logic                  grant_valid,
    output logic [IDX_W-1:0]      grant_layer,
    output logic [TAG_W-1:0]      grant_depart,
    output logic [CELL_W-1:0]     grant_data,
    output logic                  no_layer_err
);

    logic [NUM_LAYERS-1:0] link_free;
    logic [NUM_LAYERS-1:0] cand;
    logic                  cand_found;
    logic [IDX_W-1:0]      cand_idx;
    logic                  accept;
    pick_outcome_e         outcome;

    // Accept whenever a cell is offered and the port is out of reset.
    assign accept = cell_valid && cell_ready;

    // Common layers: free input link and readable at departure.
    assign cand = link_free & depart_avail;

    layer_lowest_pick #(
        .NUM_LAYERS(NUM_LAYERS),
        .IDX_W     (IDX_W)
    ) u_pick (
        .req  (cand),
        .found(cand_found),
        .idx  (cand_idx)
    );

    layer_link_tracker #(
        .NUM_LAYERS(NUM_LAYERS),
        .BUSY_SLOTS(BUSY_SLOTS),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim_en (accept && cand_found),
        .claim_idx(cand_idx),
        .link_free(link_free)
    );

    // Classify this slot's outcome.
    always_comb begin
        if (!accept) begin
            outcome = PICK_IDLE;
        end else if (cand_found) begin
            outcome = PICK_HIT;
        end else begin
            outcome = PICK_MISS;
        end
    end

    // Ready rises on the first clock after reset and stays up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_ready <= 1'b0;
        end else begin
            cell_ready <= 1'b1;
        end
    end

    // Register the grant strobe and error strobe from the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid  <= 1'b0;
            no_layer_err <= 1'b0;
        end else begin
            grant_valid  <= (outcome == PICK_HIT);
            no_layer_err <= (outcome == PICK_MISS);
        end
    end

    // Capture the chosen layer and the cell fields on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_layer  <= '0;
            grant_depart <= '0;
            grant_data   <= '0;
        end else if (outcome == PICK_HIT) begin
            grant_layer  <= cand_idx;
            grant_depart <= cell_depart;
            grant_data   <= cell_data;
        end
    end

endmodule

// File: rtl/layer_select_checker.sv
// Module: layer_select_checker
// Assertion set for layer_select_demux, attached by bind below.
// Assumes the same NUM_LAYERS and IDX_W as the checked instance.
module layer_select_checker #(
    parameter int NUM_LAYERS = 10,
    parameter int IDX_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cell_valid,
    input logic                  cell_ready,
    input logic [NUM_LAYERS-1:0] depart_avail,
    input logic [NUM_LAYERS-1:0] link_free,
    input logic                  grant_valid,
    input logic [IDX_W-1:0]      grant_layer,
    input logic                  no_layer_err
);

    logic                  prev_accept;
    logic [NUM_LAYERS-1:0] prev_avail;
    logic [NUM_LAYERS-1:0] prev_cand;

    // Remember the previous slot's acceptance and candidate sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_accept <= 1'b0;
            prev_avail  <= '0;
            prev_cand   <= '0;
        end else begin
            prev_accept <= cell_valid && cell_ready;
            prev_avail  <= depart_avail;
            prev_cand   <= depart_avail & link_free;
        end
    end

    // R1
    ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cell_ready);

    // R2
    grant_needs_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || no_layer_err) |-> prev_accept);

    // R2
    grant_readable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> prev_avail[grant_layer]);

    // R3
    lowest_layer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((prev_cand & ((NUM_LAYERS'(1) << grant_layer) - NUM_LAYERS'(1))) == '0));

    // R4
    no_reuse_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(grant_valid)) |-> (grant_layer != $past(grant_layer)));

    // R6
    miss_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        no_layer_err |-> (prev_cand == '0));

    // R8
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && no_layer_err));

endmodule

bind layer_select_demux layer_select_checker #(
    .NUM_LAYERS(NUM_LAYERS),
    .IDX_W     (IDX_W)
) u_layer_select_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cell_valid  (cell_valid),
    .cell_ready  (cell_ready),
    .depart_avail(depart_avail),
    .link_free   (link_free),
    .grant_valid (grant_valid),
    .grant_layer (grant_layer),
    .no_layer_err(no_layer_err)
);

// File: tb/test_layer_select_demux.sv
// Directed bench for layer_select_demux with a bench-side occupancy model.
module test_layer_select_demux;

    localparam int NL     = 10;
    localparam int SP     = 3;
    localparam int TW     = 16;
    localparam int CW     = 32;
    localparam int IW     = 4;
    localparam int BUSY   = (NL + SP - 1) / SP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cell_valid = 1'b0;
    logic          cell_ready;
    logic [TW-1:0] cell_depart = '0;
    logic [CW-1:0] cell_data = '0;
    logic [NL-1:0] depart_avail = '0;
    logic          grant_valid;
    logic [IW-1:0] grant_layer;
    logic [TW-1:0] grant_depart;
    logic [CW-1:0] grant_data;
    logic          no_layer_err;

    int checks = 0;
    int failures = 0;
    int mcnt [NL];
    bit finished = 0;

    always #5 clk = ~clk;

    layer_select_demux #(
        .NUM_LAYERS(NL),
        .SPEEDUP   (SP),
        .TAG_W     (TW),
        .CELL_W    (CW)
    ) i_layer_select_demux (
        .clk         (clk),
        .rst_n       (rst_n),
        .cell_valid  (cell_valid),
        .cell_ready  (cell_ready),
        .cell_depart (cell_depart),
        .cell_data   (cell_data),
        .depart_avail(depart_avail),
        .grant_valid (grant_valid),
        .grant_layer (grant_layer),
        .grant_depart(grant_depart),
        .grant_data  (grant_data),
        .no_layer_err(no_layer_err)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model: one slot passes; optionally claim layer lay.
    task automatic model_step(input int lay);
        for (int i = 0; i < NL; i++) if (mcnt[i] > 0) mcnt[i]--;
        if (lay >= 0) mcnt[lay] = BUSY - 1;
    endtask

    // Model: lowest common layer or -1.
    function automatic int model_pick(input logic [NL-1:0] av);
        for (int i = 0; i < NL; i++) if (mcnt[i] == 0 && av[i]) return i;
        return -1;
    endfunction

    // Offer one cell and check the registered result.
    task automatic send(input logic [NL-1:0] av, input logic [TW-1:0] tag, input string req);
        int exp;
        check("R1", "ready before send", cell_ready, 1);
        cell_valid   = 1'b1;
        depart_avail = av;
        cell_depart  = tag;
        cell_data    = {tag, ~tag};
        exp = model_pick(av);
        @(posedge clk);
        model_step(exp);
        @(negedge clk);
        cell_valid = 1'b0;
        if (exp >= 0) begin
            check(req, "grant_valid", grant_valid, 1);
            check(req, "grant_layer", grant_layer, exp);
            check("R2", "grant_depart", grant_depart, tag);
            check("R2", "grant_data", grant_data, {tag, ~tag});
            check("R8", "err with grant", no_layer_err, 0);
        end else begin
            check("R6", "no_layer_err", no_layer_err, 1);
            check("R6", "grant_valid on miss", grant_valid, 0);
        end
    endtask

    // One slot with no offered cell.
    task automatic idle(input logic [NL-1:0] av);
        cell_valid   = 1'b0;
        depart_avail = av;
        @(posedge clk);
        model_step(-1);
        @(negedge clk);
        check("R7", "grant_valid idle", grant_valid, 0);
        check("R7", "err idle", no_layer_err, 0);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NL; i++) mcnt[i] = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", cell_ready, 0);
        check("R1", "grant_valid in reset", grant_valid, 0);
        check("R1", "err in reset", no_layer_err, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "ready after reset", cell_ready, 1);
    endtask

    task automatic t_rotation;
        // R4: consecutive full-bitmap cells walk 0..3 then return to 0.
        send('1, 16'd100, "R4");
        check("R4", "first layer", grant_layer, 0);
        send('1, 16'd101, "R4");
        check("R4", "second layer", grant_layer, 1);
        send('1, 16'd102, "R4");
        check("R4", "third layer", grant_layer, 2);
        send('1, 16'd103, "R4");
        check("R4", "fourth layer", grant_layer, 3);
        send('1, 16'd104, "R4");
        check("R4", "wrap layer", grant_layer, 0);
        repeat (BUSY) idle('1);
    endtask

    task automatic t_priority;
        // R3: only layers 5 and 7 readable; lowest chosen.
        send(NL'(10'b0010100000), 16'd200, "R3");
        check("R3", "layer from sparse map", grant_layer, 5);
        // R5: layer 5 busy, 7 untouched and picked next.
        send(NL'(10'b0010100000), 16'd201, "R5");
        check("R5", "other layer unaffected", grant_layer, 7);
        repeat (BUSY) idle('1);
    endtask

    task automatic t_miss;
        // R6: empty departure map drops the cell.
        send('0, 16'd300, "R6");
        // R6: dropped cell occupied nothing, so layer 0 is chosen.
        send('1, 16'd301, "R6");
        check("R6", "no link occupied by drop", grant_layer, 0);
        // R4/R6: only layer 0 readable while it is busy -> miss.
        send(NL'(1), 16'd302, "R4");
        check("R4", "busy layer excluded", no_layer_err, 1);
        idle('1);
        idle('1);
        // R4: BUSY-th slot after the grant, layer 0 free again.
        send(NL'(1), 16'd303, "R4");
        check("R4", "layer free after window", grant_layer, 0);
        repeat (BUSY) idle('1);
    endtask

    task automatic t_stream;
        logic [15:0] lfsr = 16'hACE1;
        int errs = 0;
        for (int n = 0; n < 400; n++) begin
            logic [NL-1:0] av;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            av = lfsr[NL-1:0] | NL'(10'b1111 << (n % 7));
            if (lfsr[15] && lfsr[3]) idle(av);
            send(av, TW'(n), "R9");
            if (no_layer_err) errs++;
        end
        check("R9", "errors with wide maps", errs, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rotation();
        t_priority();
        t_miss();
        t_stream();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule